// File: doc/BRIEF.md
# Single-Cycle Integer Core (Nine-Instruction Subset)

This block is a 32-bit processor core that completes one instruction per clock cycle. In that one cycle it fetches an instruction word, decodes it, reads two source registers, runs the ALU, accesses data memory and writes back. It supports register-to-register add, subtract, AND, OR and signed set-less-than, word load and store, branch-if-equal and an absolute jump. Instruction storage and data storage are separate word arrays inside the core. The test environment fills both arrays before reset is released.

There are no bus ports. The core reports its behaviour through an observation port. That port shows the current program counter, every register-file write (index and value) and every data-memory write (byte address and value), each in the cycle the write takes effect. Neither memory can be read from outside the core. The only way to see internal state is through the writes it causes later and through the program counter.

Top module: `sc_core`

## Requirements
- R1: `rst` is synchronous and active high. The first rising edge with `rst` high sets `pc_o` to 0. While `rst` is high, `rf_wr_en_o` and `dm_wr_en_o` stay 0 and no state is changed.
- R2: Every instruction other than a taken branch or a jump loads PC+4 at the next edge. The instruction word is taken from instruction-memory word `pc[IAW+1:2]`.
- R3: Opcode bits [31:26] = 0 selects a register operation on rs [25:21] and rt [20:16], with the result written to rd [15:11]. The operation is chosen by bits [5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed less-than (result 1 or 0).
- R4: Opcode 35 loads a word. The address is rs + sign-extended bits [15:0]. The memory word at that address is written to rt.
- R5: Opcode 43 stores a word. The rt value is written to address rs + sign-extended bits [15:0]. `dm_wr_addr_o` shows that byte address. No register write occurs.
- R6: Opcode 4 branches when rs equals rt. A taken branch goes to PC+4 + (sign-extended bits [15:0] << 2). A branch that is not taken goes to PC+4. A branch writes neither the register file nor memory.
- R7: Opcode 2 jumps to {PC+4[31:28], bits [25:0], 2'b00}. A jump causes no writes.
- R8: Register 0 always reads as 0. An instruction that targets register 0 produces no write event and leaves it at 0.
- R9: Data memory is word addressed by address bits [DAW+1:2]. The two low address bits are ignored.
- R10: A value written by one instruction can be read by the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction executing this cycle |
| rf_wr_en_o | output | 1 | A register write takes effect at the coming edge |
| rf_wr_idx_o | output | 5 | Destination register of that write |
| rf_wr_val_o | output | 32 | Value being written |
| dm_wr_en_o | output | 1 | A data-memory write takes effect at the coming edge |
| dm_wr_addr_o | output | 32 | Byte address of the store |
| dm_wr_val_o | output | 32 | Word being stored |

## Verification
A wrong program counter shows on `pc_o` in the cycle after the faulty next-address choice. A wrong register or memory word cannot be seen directly. It appears in the first later write event that consumes it: an ALU result, a loaded value or a stored value. It can also appear as a branch outcome that redirects `pc_o` one cycle later. The bench runs an independent instruction-level model alongside the core and compares every port in every cycle. Any divergence is therefore reported in the cycle in which the corrupted state first reaches a port.

// File: rtl/sccore_pkg.sv
package sccore_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    // primary opcodes
    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    // register-operation function codes
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    // operation class handed from the main decoder to the ALU decoder
    typedef enum logic [1:0] {
        AOP_ADD   = 2'd0,
        AOP_SUB   = 2'd1,
        AOP_FUNCT = 2'd2,
        AOP_RSVD  = 2'd3
    } aluop_e;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_AND = 3'd2,
        ALU_OR  = 3'd3,
        ALU_SLT = 3'd4
    } alusel_e;

    typedef struct packed {
        logic   dst_rd;   // destination from rd field instead of rt
        logic   src_imm;  // ALU second operand is the extended immediate
        logic   wb_mem;   // write-back value comes from data memory
        logic   rf_we;
        logic   dm_we;
        logic   is_beq;
        logic   is_jump;
        aluop_e aluop;
    } ctl_t;

    typedef struct packed {
        logic [5:0] op;
        ridx_t      rs;
        ridx_t      rt;
        logic [15:0] imm;
    } ifmt_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
    import sccore_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output alusel_e    alu_sel
);

    // main decoder
    always_comb begin
        ctl = '0;
        ctl.aluop = AOP_ADD;
        case (op)
            OPC_RTYPE: begin
                ctl.dst_rd = 1'b1;
                ctl.rf_we  = 1'b1;
                ctl.aluop  = AOP_FUNCT;
            end
            OPC_LOAD: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.rf_we   = 1'b1;
            end
            OPC_STORE: begin
                ctl.src_imm = 1'b1;
                ctl.dm_we   = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_beq = 1'b1;
                ctl.aluop  = AOP_SUB;
            end
            OPC_JUMP: begin
                ctl.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

    // ALU decoder
    always_comb begin
        case (ctl.aluop)
            AOP_SUB: alu_sel = ALU_SUB;
            AOP_FUNCT: begin
                case (funct)
                    FN_SUB:  alu_sel = ALU_SUB;
                    FN_AND:  alu_sel = ALU_AND;
                    FN_OR:   alu_sel = ALU_OR;
                    FN_SLT:  alu_sel = ALU_SLT;
                    default: alu_sel = ALU_ADD;
                endcase
            end
            default: alu_sel = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sccore_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alusel_e sel,
    output word_t   y,
    output logic    zero
);

    always_comb begin
        case (sel)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = word_t'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sccore_pkg::*;
#(
    parameter int NREG = 32
) (
    input  logic  clk,
    input  logic  we,
    input  ridx_t wa,
    input  word_t wd,
    input  ridx_t ra1,
    input  ridx_t ra2,
    output word_t rd1,
    output word_t rd2
);

    word_t bank [NREG];

    // entry 0 is never written; reads of it are forced to zero below
    always_ff @(posedge clk) begin
        if (we && wa != '0) begin
            bank[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : bank[ra1];
    assign rd2 = (ra2 == '0) ? '0 : bank[ra2];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sccore_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 64,
    parameter int NREG       = 32
) (
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] pc_o,
    output logic        rf_wr_en_o,
    output logic [4:0]  rf_wr_idx_o,
    output logic [31:0] rf_wr_val_o,
    output logic        dm_wr_en_o,
    output logic [31:0] dm_wr_addr_o,
    output logic [31:0] dm_wr_val_o
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    word_t   pc_q;
    word_t   pc_next;
    word_t   pc_plus4;
    word_t   br_target;
    word_t   jmp_target;
    word_t   instr;
    ifmt_t   fld;
    word_t   imm_ext;
    ctl_t    ctl;
    alusel_e alu_sel;
    word_t   rs_val;
    word_t   rt_val;
    word_t   alu_b;
    word_t   alu_y;
    logic    alu_zero;
    word_t   mem_rdata;
    word_t   wb_val;
    ridx_t   wb_idx;
    logic    rf_we_eff;
    logic    dm_we_eff;

    word_t imem_q [IMEM_WORDS];
    word_t dmem_q [DMEM_WORDS];

    // instruction storage is filled by the environment; start from zeros
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) begin
            imem_q[i] = '0;
        end
    end

    // fetch
    assign instr   = imem_q[pc_q[IAW+1:2]];
    assign fld     = ifmt_t'(instr);
    assign imm_ext = sext16(fld.imm);

    sc_ctrl u_ctrl (
        .op      (fld.op),
        .funct   (instr[5:0]),
        .ctl     (ctl),
        .alu_sel (alu_sel)
    );

    assign wb_idx    = ctl.dst_rd ? ridx_t'(instr[15:11]) : fld.rt;
    assign rf_we_eff = ctl.rf_we && !rst && (wb_idx != '0);
    assign dm_we_eff = ctl.dm_we && !rst;

    sc_regfile #(.NREG(NREG)) u_rf (
        .clk (clk),
        .we  (rf_we_eff),
        .wa  (wb_idx),
        .wd  (wb_val),
        .ra1 (fld.rs),
        .ra2 (fld.rt),
        .rd1 (rs_val),
        .rd2 (rt_val)
    );

    assign alu_b = ctl.src_imm ? imm_ext : rt_val;

    sc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .sel  (alu_sel),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: combinational read, clocked write
    assign mem_rdata = dmem_q[alu_y[DAW+1:2]];
    assign wb_val    = ctl.wb_mem ? mem_rdata : alu_y;

    always_ff @(posedge clk) begin
        if (dm_we_eff) begin
            dmem_q[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    // next address: dedicated adders, separate from the ALU
    assign pc_plus4   = pc_q + word_t'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.is_jump) begin
            pc_next = jmp_target;
        end else if (ctl.is_beq && alu_zero) begin
            pc_next = br_target;
        end else begin
            pc_next = pc_plus4;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    // observation port
    assign pc_o         = pc_q;
    assign rf_wr_en_o   = rf_we_eff;
    assign rf_wr_idx_o  = wb_idx;
    assign rf_wr_val_o  = wb_val;
    assign dm_wr_en_o   = dm_we_eff;
    assign dm_wr_addr_o = alu_y;
    assign dm_wr_val_o  = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sccore_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        rf_wr_en_o,
    input logic [4:0]  rf_wr_idx_o,
    input logic        dm_wr_en_o
);

    logic [5:0] op;
    assign op = instr[31:26];

    a_r1_pc_cleared: assert property (@(posedge clk)
        rst |=> pc_o == 32'd0);

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        rst |-> (!rf_wr_en_o && !dm_wr_en_o));

    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (op != OPC_BEQ && op != OPC_JUMP) |=> pc_o == $past(pc_o) + 32'd4);

    a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_o[1:0] == 2'b00);

    a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
        dm_wr_en_o |-> (op == OPC_STORE && !rf_wr_en_o));

    a_r6_not_taken: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ && rs_val != rt_val) |=> pc_o == $past(pc_o) + 32'd4);

    a_r6_no_writes: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_BEQ || op == OPC_JUMP) |-> (!rf_wr_en_o && !dm_wr_en_o));

    a_r7_jump_field: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JUMP) |=> pc_o[27:2] == $past(instr[25:0]));

    a_r8_no_zero_write: assert property (@(posedge clk) disable iff (rst)
        rf_wr_en_o |-> rf_wr_idx_o != 5'd0);

endmodule

bind sc_core sc_core_chk i_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_o        (pc_o),
    .instr       (instr),
    .rs_val      (rs_val),
    .rt_val      (rt_val),
    .rf_wr_en_o  (rf_wr_en_o),
    .rf_wr_idx_o (rf_wr_idx_o),
    .dm_wr_en_o  (dm_wr_en_o)
);

// File: tb/test_sc_core.sv
module test_sc_core;
    import sccore_pkg::*;

    localparam int IW = 256;
    localparam int DW = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        rf_wr_en_o;
    logic [4:0]  rf_wr_idx_o;
    logic [31:0] rf_wr_val_o;
    logic        dm_wr_en_o;
    logic [31:0] dm_wr_addr_o;
    logic [31:0] dm_wr_val_o;

    always #10 clk = ~clk;

    sc_core i_sc_core (
        .clk          (clk),
        .rst          (rst),
        .pc_o         (pc_o),
        .rf_wr_en_o   (rf_wr_en_o),
        .rf_wr_idx_o  (rf_wr_idx_o),
        .rf_wr_val_o  (rf_wr_val_o),
        .dm_wr_en_o   (dm_wr_en_o),
        .dm_wr_addr_o (dm_wr_addr_o),
        .dm_wr_val_o  (dm_wr_val_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    bit    reported = 0;
    bit    prog_a = 0;
    word_t prog [IW];
    word_t m_rf [32];
    word_t m_dm [DW];
    word_t m_pc;
    string prev_tag = "R1";

    function automatic word_t enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic word_t enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic word_t enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_dm(int idx, word_t v);
        i_sc_core.dmem_q[idx] = v;
        m_dm[idx] = v;
    endtask

    task automatic load_prog();
        for (int i = 0; i < IW; i++) begin
            i_sc_core.imem_q[i] = prog[i];
        end
    endtask

    // reset sequence; R1 checked while held and on release
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk("R1", "pc in reset", pc_o, 32'd0);
        chk("R1", "reg write in reset", {31'd0, rf_wr_en_o}, 32'd0);
        chk("R1", "mem write in reset", {31'd0, dm_wr_en_o}, 32'd0);
        rst = 1'b0;
        m_pc = 32'd0;
        prev_tag = "R1";
        #1;
    endtask

    // one instruction of the reference model, compared against the ports
    task automatic step_check();
        word_t      ins   = prog[m_pc[9:2]];
        logic [5:0] op    = ins[31:26];
        logic [5:0] fn    = ins[5:0];
        int         rs    = int'(ins[25:21]);
        int         rt    = int'(ins[20:16]);
        int         rd    = int'(ins[15:11]);
        word_t      a     = m_rf[rs];
        word_t      b     = m_rf[rt];
        word_t      simm  = {{16{ins[15]}}, ins[15:0]};
        word_t      npc   = m_pc + 32'd4;
        bit         e_rwe = 0;
        int         e_idx = 0;
        word_t      e_rv  = '0;
        bit         e_dwe = 0;
        word_t      e_da  = '0;
        word_t      e_dv  = '0;
        string      tg    = "R2";

        case (op)
            6'd0: begin
                tg = (rd == 0) ? "R8" : "R3";
                e_idx = rd;
                e_rwe = (rd != 0);
                case (fn)
                    6'h22:   e_rv = a - b;
                    6'h24:   e_rv = a & b;
                    6'h25:   e_rv = a | b;
                    6'h2A:   e_rv = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: e_rv = a + b;
                endcase
            end
            6'd35: begin
                tg = "R4";
                e_da = a + simm;
                e_rv = m_dm[e_da[7:2]];   // R9: low two bits dropped
                e_idx = rt;
                e_rwe = (rt != 0);
            end
            6'd43: begin
                tg = "R5";
                e_dwe = 1;
                e_da = a + simm;
                e_dv = b;
            end
            6'd4: begin
                tg = "R6";
                if (a == b) npc = m_pc + 32'd4 + (simm << 2);
            end
            6'd2: begin
                tg = "R7";
                npc = {npc[31:28], ins[25:0], 2'b00};
            end
            default: ;
        endcase

        chk(prev_tag, "pc", pc_o, m_pc);
        chk(tg, "reg write enable", {31'd0, rf_wr_en_o}, {31'd0, e_rwe});
        if (e_rwe) begin
            chk(tg, "reg write index", {27'd0, rf_wr_idx_o}, 32'(e_idx));
            chk(tg, "reg write value", rf_wr_val_o, e_rv);
        end
        chk(tg, "mem write enable", {31'd0, dm_wr_en_o}, {31'd0, e_dwe});
        if (e_dwe) begin
            chk(tg, "mem write address", dm_wr_addr_o, e_da);
            chk(tg, "mem write value", dm_wr_val_o, e_dv);
        end

        // hand-derived values for program A
        if (prog_a) begin
            if (m_pc == 32'd52) chk("R8", "r0 reads zero", rf_wr_val_o, 32'd0);
            if (m_pc == 32'd60) chk("R10", "value written one cycle earlier", rf_wr_val_o, 32'hFFFF_FFF7);
            if (m_pc == 32'd68) chk("R9", "offset with low bits set", rf_wr_val_o, 32'd7);
        end

        if (e_rwe) m_rf[e_idx] = e_rv;
        if (e_dwe) m_dm[e_da[7:2]] = e_dv;
        m_pc = npc;
        prev_tag = tg;
    endtask

    task automatic run(int n);
        step_check();
        for (int i = 1; i < n; i++) begin
            @(negedge clk);
            #1;
            step_check();
        end
    endtask

    task automatic build_prog_a();
        for (int i = 0; i < IW; i++) prog[i] = enc_j(i);
        for (int i = 0; i < DW; i++) put_dm(i, 32'd0);
        put_dm(0, 32'd7);
        put_dm(1, 32'hFFFF_FFF0);
        put_dm(3, 32'h20);
        put_dm(4, 32'd3);
        put_dm(5, 32'd1);
        prog[0]  = enc_i(6'd35, 0, 1, 0);
        prog[1]  = enc_i(6'd35, 0, 2, 4);
        prog[2]  = enc_i(6'd35, 0, 13, 12);
        prog[3]  = enc_i(6'd35, 0, 15, 16);
        prog[4]  = enc_i(6'd35, 0, 16, 20);
        prog[5]  = enc_r(1, 2, 3, 6'h20);
        prog[6]  = enc_r(1, 2, 4, 6'h22);
        prog[7]  = enc_r(1, 2, 5, 6'h24);
        prog[8]  = enc_r(1, 2, 6, 6'h25);
        prog[9]  = enc_r(2, 1, 7, 6'h2A);       // negative < positive
        prog[10] = enc_r(1, 2, 8, 6'h2A);
        prog[11] = enc_r(1, 1, 17, 6'h2A);      // equal operands
        prog[12] = enc_r(1, 1, 0, 6'h20);       // R8 target r0
        prog[13] = enc_r(0, 0, 9, 6'h20);       // R8 read r0
        prog[14] = enc_i(6'd43, 0, 3, 8);
        prog[15] = enc_i(6'd35, 0, 10, 8);      // R10
        prog[16] = enc_i(6'd43, 13, 1, -4);     // negative offset
        prog[17] = enc_i(6'd35, 0, 14, 30);     // R9 address 0x1E
        prog[18] = enc_i(6'd4, 1, 1, 2);        // taken forward
        prog[19] = enc_r(1, 1, 20, 6'h20);
        prog[20] = enc_r(1, 1, 21, 6'h20);
        prog[21] = enc_i(6'd4, 1, 2, 5);        // not taken
        prog[22] = enc_r(15, 16, 15, 6'h22);
        prog[23] = enc_i(6'd4, 15, 0, 1);
        prog[24] = enc_i(6'd4, 0, 0, -3);       // taken backward
        prog[25] = enc_j(27);
        prog[26] = enc_r(1, 1, 22, 6'h20);
        prog[27] = enc_i(6'd43, 0, 15, 24);
        prog[28] = enc_j(28);
    endtask

    task automatic build_prog_b();
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        for (int i = 0; i < IW; i++) prog[i] = enc_j(i);
        for (int i = 0; i < DW; i++) put_dm(i, $urandom());
        put_dm(6, m_dm[5]);
        put_dm(7, 32'h8000_0000);
        put_dm(8, 32'h7FFF_FFFF);
        for (int i = 0; i < 31; i++) prog[i] = enc_i(6'd35, 0, i + 1, i * 4);
        for (int i = 31; i < 240; i++) begin
            int k  = int'($urandom_range(7, 0));
            int ra = int'($urandom_range(31, 0));
            int rb = int'($urandom_range(31, 0));
            int rc = int'($urandom_range(31, 0));
            int w  = int'($urandom_range(DW - 1, 0));
            if (k < 5)       prog[i] = enc_r(ra, rb, rc, fns[k]);
            else if (k == 5) prog[i] = enc_i(6'd43, 0, rb, w * 4 + int'($urandom_range(3, 0)));
            else if (k == 6) prog[i] = enc_i(6'd35, 0, rb, w * 4);
            else             prog[i] = enc_i(6'd4, ra, (ra + rb) % 2 == 0 ? ra : rb, 1);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        end
    endtask

    initial begin
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = '0;

        build_prog_a();
        load_prog();
        prog_a = 1;
        do_reset();
        run(40);
        prog_a = 0;

        // mid-run reset: registers and memory keep their contents (R1)
        do_reset();
        run(10);

        build_prog_b();
        load_prog();
        do_reset();
        run(250);

        summary();
        $finish;
    end

    initial begin
        #(64'd20 * 64'd150000);
        n_err++;
        $display("FAIL R2 watchdog: actual running expected finished");
        summary();
        $finish;
    end

endmodule